// File: doc/BRIEF.md
# Bus Mouse Adapter Register Interface

This block is the host-facing register set of a bus mouse adapter built around a parallel-port style programmable interface. It decodes a window of four consecutive I/O addresses on a byte-wide bus. The read and write sides each have their own address and strobe, and the read data is registered. Within the window, one offset holds the configuration port and one holds the control port. The two remaining offsets read back as all ones.

The top bit of a configuration write chooses between two operations:
- With the bit set, the write is a mode-set. It stores the byte, marks the adapter active, reloads the control port and restarts the periodic interrupt timer. A driver typically writes 0x91 here, which turns port B and the upper half of port C into outputs. Bits 6:5 of the stored byte carry the port A mode (00 basic, 01 strobed).
- With the bit clear, the write flips a single bit of the control port. The stored configuration and the active state do not change.

Every read of the control port returns its present value and then forces the port's low nibble back to ones. A free-running timer produces one tick per period, where the period is the clock rate divided by the tick rate. Each tick raises the interrupt output for one cycle, but only once the adapter is active.

Top module: `pmouse_port_regs`

## Requirements
- R1: After reset the configuration port reads 0x9B and the control port reads 0x0F. Also after reset, `rd_data` is 0xFF and `active` and `irq` are low.
- R2: Only addresses BASE to BASE+3 respond. A read strobe outside the window leaves `rd_data` unchanged, and a write strobe outside the window changes no register.
- R3: A write to offset 3 with bit 7 = 1 is a mode-set. It stores the whole byte as the configuration and sets `active` to 1. It also loads the control port with 0x0F & ~IRQ_MASK.
- R4: A write to offset 3 with bit 7 = 0 leaves the configuration value and `active` unchanged. Control bit number wr_data[3:1] becomes wr_data[0], and the other control bits are unchanged.
- R5: A read strobe at offset 2 puts the control value in `rd_data` one cycle later. After the read, control bits 3:0 are 1 and bits 7:4 are unchanged.
- R6: A control read in the same cycle as a bit set/reset returns the old control value. The bit set/reset is then applied on top of the restored value, that is, to (old | 0x0F).
- R7: A write to offset 2 stores the byte in the control port. If a control read falls in the same cycle, the written byte wins over the low-nibble restore.
- R8: Reads of offsets 0 and 1 return 0xFF. A read of offset 3 returns the stored configuration.
- R9: The tick timer has a period of CLK_HZ/TICK_HZ cycles and runs from reset. A mode-set write restarts it, so the first tick after a mode-set comes PERIOD-1 cycles after that write's clock edge, and later ticks follow every PERIOD cycles.
- R10: `irq` is high for exactly one cycle per tick, and only while `active` is 1. Before any mode-set, `irq` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | One-cycle interrupt pulse per timer tick |
| active | output | 1 | Set by the first mode-set write |

## Verification
Because the read and write ports are separate, a control-port read and a configuration bit set/reset can land on the same clock edge. In that cycle two sources drive the control register: the read's nibble restore and the single-bit update. The bench provokes this by raising both strobes together for every bit set/reset command byte, each against a different preloaded control value. It judges the outcome twice: the read data must show the value before the restore, and a follow-up read must show the bit update applied on top of the restored nibble. The same collision is also provoked with a direct control write, where the written byte must win.

// File: rtl/pmouse_pkg.sv
package pmouse_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned SEL_W  = $clog2(BYTE_W);

   typedef logic [BYTE_W-1:0] byte_t;

   // register offsets inside the four-address window
   typedef enum logic [1:0] {
      OFS_DATA = 2'd0,
      OFS_SIG  = 2'd1,
      OFS_CTRL = 2'd2,
      OFS_CFG  = 2'd3
   } ofs_e;

   localparam byte_t CFG_RESET    = 8'h9B;
   localparam byte_t CTRL_RESET   = 8'h0F;
   localparam byte_t IDLE_READ    = 8'hFF;
   localparam byte_t RESTORE_MASK = 8'h0F;
   localparam int unsigned MODE_BIT = 7;

endpackage

// File: rtl/pmouse_decode.sv
module pmouse_decode
   import pmouse_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned BASE   = 32'h23C
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output ofs_e              ofs
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("pmouse_decode: ADDR_W must be at least 3");
      end
      if ((BASE % 4) != 0) begin : g_bad_base
         $error("pmouse_decode: BASE must be aligned to four");
      end
   endgenerate

   logic in_window;

   assign in_window = (addr[ADDR_W-1:2] == BASE_A[ADDR_W-1:2]);
   assign hit       = en && in_window;
   assign ofs       = ofs_e'(addr[1:0]);

endmodule

// File: rtl/pmouse_ctrl_reg.sv
module pmouse_ctrl_reg
   import pmouse_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rd_hit,    // control read: restore low nibble
   input  logic  ld_en,     // mode-set reload
   input  byte_t ld_val,
   input  logic  wr_en,     // direct write
   input  byte_t wr_val,
   input  logic  bsr_en,    // single-bit set/reset
   input  logic [SEL_W-1:0] bsr_sel,
   input  logic  bsr_val,
   output byte_t q
);

   byte_t restored;
   byte_t nxt;

   assign restored = rd_hit ? (q | RESTORE_MASK) : q;

   // per-bit next state: reload > write > bit set/reset > restored
   generate
      for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
         assign nxt[b] = ld_en  ? ld_val[b] :
                         wr_en  ? wr_val[b] :
                         (bsr_en && (bsr_sel == SEL_W'(b))) ? bsr_val :
                         restored[b];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= CTRL_RESET;
      else        q <= nxt;
   end

endmodule

// File: rtl/pmouse_tick.sv
module pmouse_tick #(
   parameter int unsigned PERIOD = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("pmouse_tick: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             count <= '0;
      else if (restart)       count <= '0;
      else if (count == LAST) count <= '0;
      else                    count <= count + 1'b1;
   end

   assign tick = (count == LAST);

endmodule

// File: rtl/pmouse_port_regs.sv
module pmouse_port_regs
   import pmouse_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned BASE     = 32'h23C,
   parameter int unsigned CLK_HZ   = 50_000_000,
   parameter int unsigned TICK_HZ  = 30,
   parameter logic [7:0]  IRQ_MASK = 8'h0F,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              irq,
   output logic              active
);

   localparam int unsigned PERIOD  = CLK_HZ / TICK_HZ;
   localparam byte_t       LD_CTRL = RESTORE_MASK & ~IRQ_MASK;

   generate
      if (TICK_HZ == 0 || CLK_HZ < 2 * TICK_HZ) begin : g_bad_rate
         $error("pmouse_port_regs: CLK_HZ must be at least twice TICK_HZ");
      end
      if ((IRQ_MASK & ~RESTORE_MASK) != 8'h00) begin : g_bad_mask
         $error("pmouse_port_regs: IRQ_MASK must lie in the low nibble");
      end
   endgenerate

   // address decode
   logic rd_hit, wr_hit;
   ofs_e rd_ofs, wr_ofs;

   pmouse_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_rd_dec (
      .en(rd_en), .addr(rd_addr), .hit(rd_hit), .ofs(rd_ofs)
   );

   pmouse_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_wr_dec (
      .en(wr_en), .addr(wr_addr), .hit(wr_hit), .ofs(wr_ofs)
   );

   logic cfg_wr, ctrl_wr, ctrl_rd, mode_set, bit_op;

   assign cfg_wr   = wr_hit && (wr_ofs == OFS_CFG);
   assign ctrl_wr  = wr_hit && (wr_ofs == OFS_CTRL);
   assign ctrl_rd  = rd_hit && (rd_ofs == OFS_CTRL);
   assign mode_set = cfg_wr &&  wr_data[MODE_BIT];
   assign bit_op   = cfg_wr && !wr_data[MODE_BIT];

   // configuration register and active flag
   byte_t cfg_q;
   logic  active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= CFG_RESET;
         active_q <= 1'b0;
      end else if (mode_set) begin
         cfg_q    <= wr_data;
         active_q <= 1'b1;
      end
   end

   // control register
   byte_t ctrl_q;

   pmouse_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_hit  (ctrl_rd),
      .ld_en   (mode_set),
      .ld_val  (LD_CTRL),
      .wr_en   (ctrl_wr),
      .wr_val  (wr_data),
      .bsr_en  (bit_op),
      .bsr_sel (wr_data[3:1]),
      .bsr_val (wr_data[0]),
      .q       (ctrl_q)
   );

   // registered read path
   byte_t rd_q, rd_mux;

   always_comb begin
      unique case (rd_ofs)
         OFS_CTRL: rd_mux = ctrl_q;
         OFS_CFG:  rd_mux = cfg_q;
         default:  rd_mux = IDLE_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= IDLE_READ;
      else if (rd_hit) rd_q <= rd_mux;
   end

   assign rd_data = rd_q;
   assign active  = active_q;

   // periodic tick and interrupt pulse
   logic tick;

   pmouse_tick #(.PERIOD(PERIOD)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(mode_set), .tick(tick)
   );

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= tick && active_q;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = tick && active_q;
      end
   endgenerate

endmodule

// File: rtl/pmouse_port_regs_chk.sv
module pmouse_port_regs_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned BASE   = 32'h23C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        rd_data,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              irq,
   input logic              active,
   input logic [7:0]        ctrl_q,
   input logic [7:0]        cfg_q
);

   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(BASE + 3);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + 2);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(BASE + 3);

   logic rd_in, w_cfg, w_ctrl, r_ctrl;

   assign rd_in  = rd_en && (rd_addr >= A_LO) && (rd_addr <= A_HI);
   assign w_cfg  = wr_en && (wr_addr == A_CFG);
   assign w_ctrl = wr_en && (wr_addr == A_CTRL);
   assign r_ctrl = rd_en && (rd_addr == A_CTRL);

   a_r2_idle_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_in |=> $stable(rd_data));

   a_r3_modeset_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cfg && wr_data[7]) |=> (active && cfg_q == $past(wr_data)));

   a_r4_bitop_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (w_cfg && !wr_data[7]) |=> ($stable(cfg_q) && $stable(active)));

   a_r5_nibble_restored: assert property (@(posedge clk) disable iff (!rst_n)
      (r_ctrl && !w_cfg && !w_ctrl) |=> (ctrl_q[3:0] == 4'hF));

   a_r6_read_sees_old: assert property (@(posedge clk) disable iff (!rst_n)
      r_ctrl |=> (rd_data == $past(ctrl_q)));

   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      w_ctrl |=> (ctrl_q == $past(wr_data)));

   a_r10_irq_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> active);

   a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

endmodule

bind pmouse_port_regs pmouse_port_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (.*);

// File: tb/pmouse_port_regs_test.sv
module pmouse_port_regs_test;

   localparam int unsigned AW     = 10;
   localparam int unsigned BASE   = 32'h23C;
   localparam int unsigned PERIOD = 12;
   localparam logic [7:0]  MASK   = 8'h0F;
   localparam logic [AW-1:0] A_DATA = AW'(BASE);
   localparam logic [AW-1:0] A_SIG  = AW'(BASE + 1);
   localparam logic [AW-1:0] A_CTRL = AW'(BASE + 2);
   localparam logic [AW-1:0] A_CFG  = AW'(BASE + 3);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          irq;
   logic          active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pmouse_port_regs #(
      .ADDR_W(AW), .BASE(BASE), .CLK_HZ(PERIOD * 100), .TICK_HZ(100),
      .IRQ_MASK(MASK), .IRQ_REG(1'b0)
   ) uut (.*);

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one bus cycle; called and returns at a falling edge
   task automatic bus(input logic re, input logic [AW-1:0] ra,
                      input logic we, input logic [AW-1:0] wa,
                      input logic [7:0] wd, output logic [7:0] rv);
      rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      rv = rd_data;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      bus(1'b1, a, 1'b0, '0, 8'h00, v);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      bus(1'b0, '0, 1'b1, a, d, dummy);
   endtask

   function automatic logic [7:0] bit_op(input logic [7:0] cur, input logic [7:0] cmd);
      logic [7:0] m;
      m = 8'h01 << cmd[3:1];
      return cmd[0] ? (cur | m) : (cur & ~m);
   endfunction

   initial begin
      logic [7:0] v, p;
      int bad;
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1 rd_data in reset", rd_data, 8'hFF);
      check("R1 active in reset", {7'd0, active}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_CFG, v);  check("R1 cfg reset", v, 8'h9B);
      rd(A_CTRL, v); check("R1 ctrl reset", v, 8'h0F);

      // R10: no irq before any mode-set
      bad = 0;
      for (int i = 0; i < 3 * PERIOD; i++) begin
         if (irq) bad++;
         @(negedge clk);
      end
      check("R10 irq before mode-set", 8'(bad), 8'h00);

      // R8: unused offsets
      rd(A_DATA, v); check("R8 offset 0", v, 8'hFF);
      rd(A_SIG, v);  check("R8 offset 1", v, 8'hFF);

      // R2: outside the window
      wr(A_CTRL, 8'h3C);
      rd(A_CTRL, v);  check("R2 setup", v, 8'h3C);
      rd(AW'(BASE + 4), v); check("R2 read above window", v, 8'h3C);
      rd(AW'(BASE - 1), v); check("R2 read below window", v, 8'h3C);
      rd(A_CTRL ^ AW'(10'h100), v); check("R2 read alias", v, 8'h3C);
      wr(AW'(BASE + 6), 8'h55);
      wr(AW'(BASE + 7), 8'h80);
      wr(A_CFG ^ AW'(10'h200), 8'h81);
      rd(A_CTRL, v); check("R2 write outside ctrl", v, 8'h3F);
      rd(A_CFG, v);  check("R2 write outside cfg", v, 8'h9B);
      check("R2 write outside active", {7'd0, active}, 8'h00);

      // R5 / R7: every control value written, read, read again
      for (int k = 0; k < 256; k++) begin
         wr(A_CTRL, 8'(k));
         rd(A_CTRL, v); check("R7 ctrl write", v, 8'(k));
         rd(A_CTRL, v); check("R5 nibble restore", v, 8'(k) | 8'h0F);
      end

      // R7: write and read of control in the same cycle
      wr(A_CTRL, 8'hA0);
      bus(1'b1, A_CTRL, 1'b1, A_CTRL, 8'h42, v);
      check("R7 same-cycle read old", v, 8'hA0);
      rd(A_CTRL, v); check("R7 write beats restore", v, 8'h42);

      // R4: every bit set/reset command
      for (int c = 0; c < 128; c++) begin
         p = 8'((c * 37) ^ 8'h5A);
         wr(A_CTRL, p);
         wr(A_CFG, 8'(c));
         rd(A_CTRL, v); check("R4 bit op result", v, bit_op(p, 8'(c)));
         rd(A_CFG, v);  check("R4 cfg unchanged", v, 8'h9B);
         check("R4 active unchanged", {7'd0, active}, 8'h00);
      end

      // R6: control read collides with bit set/reset
      for (int c = 0; c < 128; c++) begin
         p = 8'((c * 91) ^ 8'hC3);
         wr(A_CTRL, p);
         bus(1'b1, A_CTRL, 1'b1, A_CFG, 8'(c), v);
         check("R6 collision read old", v, p);
         rd(A_CTRL, v); check("R6 collision result", v, bit_op(p | 8'h0F, 8'(c)));
      end

      // R3: every mode-set byte
      for (int c = 128; c < 256; c++) begin
         wr(A_CTRL, 8'hF5);
         wr(A_CFG, 8'(c));
         check("R3 active set", {7'd0, active}, 8'h01);
         rd(A_CFG, v);  check("R3 cfg stored", v, 8'(c));
         rd(A_CTRL, v); check("R3 ctrl reload", v, 8'h0F & ~MASK);
      end

      // R4: bit op after mode-set keeps the driver configuration
      wr(A_CFG, 8'h91);
      wr(A_CFG, 8'h0B);
      rd(A_CFG, v); check("R4 cfg kept after mode-set", v, 8'h91);
      check("R4 active kept", {7'd0, active}, 8'h01);

      // R9 / R10: tick timing after a mode-set, then a restart mid-period
      for (int rep = 0; rep < 2; rep++) begin
         wr(A_CFG, 8'h91);
         bad = 0;
         for (int i = 0; i < 2 * PERIOD + 3; i++) begin
            if (irq !== ((i % PERIOD) == PERIOD - 1)) bad++;
            @(negedge clk);
         end
         check("R9 tick period after mode-set", 8'(bad), 8'h00);
         repeat (5) @(negedge clk);
      end
      wr(A_CFG, 8'h91);
      repeat (4) @(negedge clk);
      wr(A_CFG, 8'h9B);
      bad = 0;
      for (int i = 0; i < PERIOD; i++) begin
         if (irq !== (i == PERIOD - 1)) bad++;
         @(negedge clk);
      end
      check("R10 restart single pulse", 8'(bad), 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule